// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

A synchronous controller for an asynchronous fast-page-mode DRAM array of 4M words by 32 bits. A host presents read or write requests with a 22-bit word address, write data and a same-row hint. The controller splits the address into an 11-bit row (upper half) and an 11-bit column (lower half), sends both over one multiplexed 11-bit bus, and drives the active-low row strobe, column strobe and write enable. Write data leaves on a separate output bus with an enable, and read data comes in on a separate input bus.

After reset the controller waits out a start-up delay. It then issues a fixed number of refresh cycles of the column-before-row type and only after that serves host accesses. While running it produces one refresh per refresh interval. A pending refresh is served between host accesses: an open row is first closed and precharged. When a request carries the same-row hint, the row stays open after the access. A later request to that row then needs only a column strobe cycle. A request to another row closes the page.

The host holds `req_i` and its fields until `ack_o` pulses for one cycle, and changes or drops them in the cycle after that pulse. On a read, `rdata_o` is valid while `ack_o` is high. All timings are given in clock cycles by parameters, so the same design fits other speed grades.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and straight after reset the row strobe, column strobe and write enable are high, the data output enable is low and `ack_o` is low.
- R2: No row is activated for an access and no `ack_o` is given before INIT_WAIT cycles have passed and INIT_REFRESH refresh cycles have been issued.
- R3: In a refresh cycle the column strobe has been low for at least T_CSR cycles when the row strobe falls, write enable is high, and the column strobe stays low while the row strobe is low.
- R4: Once initialised, successive refresh row-strobe falls are REF_INTERVAL cycles apart, within a latency of a few access times. A row left open by the same-row hint is closed before the refresh, so the next access to it activates the row again.
- R5: The row strobe is high for at least T_RP cycles before each fall. At an access activation the bus carries `addr_i[21:11]`, and the first column strobe fall comes at least T_RCD cycles later.
- R6: A write drives the column `addr_i[10:0]` on the bus, write enable low and `dram_dq_o` equal to the write data with `dram_dq_oe_o` high, all while the column strobe is low.
- R7: A read returns on `rdata_o` the word at the end of a column strobe low phase of T_CAS cycles, which is at least T_RCD+T_CAS cycles after the row strobe falls. The word read is the one last written to that address.
- R8: Requests to the same row, where the preceding request carried `burst_i`=1, are served with the row strobe held low. Only the column strobe toggles, and it stays high for at least T_CP cycles between accesses.
- R9: A request to a different row while a row is open closes the open row and activates the new one.
- R10: `ack_o` is high for exactly one cycle per served request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address: row in [21:11], column in [10:0] |
| wdata_i | input | 32 | Write data |
| burst_i | input | 1 | Same-row hint: keep the row open after this access |
| ack_o | output | 1 | One-cycle acknowledge; read data valid with it |
| rdata_o | output | 32 | Read data |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_addr_o | output | 11 | Multiplexed row/column address |
| dram_dq_o | output | 32 | Write data to the array |
| dram_dq_oe_o | output | 1 | Output enable for dram_dq_o |
| dram_dq_i | input | 32 | Read data from the array |

## Verification
The bench builds the controller with INIT_WAIT=100 and REF_INTERVAL=300 in place of the full start-up delay and refresh period, and keeps the 100 MHz strobe timings. At that scale the start-up sequence and many periodic refreshes fit in a short run. A refresh can therefore land inside open-page bursts and during a long hold of an open row. The array model returns data only while the column strobe is low, so a read sampled at the wrong cycle, or a swapped row/column half, shows up as a data mismatch.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RAS_DLY,
    S_CAS_LO,
    S_CAS_PRE,
    S_PAGE_HOLD,
    S_PRECHG,
    S_REF_CSR,
    S_REF_RAS
  } seq_state_e;
endpackage

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned INIT_WAIT    = 20000,
  parameter int unsigned INIT_REFRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic ref_req_o,
  output logic init_done_o
);
  localparam int unsigned WW = $clog2(INIT_WAIT + 1);
  localparam int unsigned IW = $clog2(REF_INTERVAL + 1);
  localparam int unsigned NW = $clog2(INIT_REFRESH + 1);

  logic [WW-1:0] wait_q;
  logic [NW-1:0] left_q;
  logic [IW-1:0] ivl_q;
  logic          pend_q;
  logic          waiting, tick;

  assign waiting     = (wait_q != '0);
  assign init_done_o = !waiting && (left_q == '0);
  assign tick        = init_done_o && (ivl_q == IW'(REF_INTERVAL - 1));
  assign ref_req_o   = !waiting && ((left_q != '0) || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= WW'(INIT_WAIT);
      left_q <= NW'(INIT_REFRESH);
      ivl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (waiting) wait_q <= wait_q - 1'b1;
      if (grant_i && left_q != '0) left_q <= left_q - 1'b1;
      if (init_done_o) begin
        ivl_q  <= tick ? '0 : ivl_q + 1'b1;
        pend_q <= tick | (pend_q & ~grant_i);
      end
    end
  end

  // an interval must never expire while the previous refresh is still owed
  assert_no_lost_refresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (!pend_q || grant_i));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 11,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DA_W   = 11,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 4,
  parameter int unsigned T_CP   = 1,
  parameter int unsigned T_RP   = 4,
  parameter int unsigned T_CSR  = 1,
  parameter int unsigned T_RAS  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   burst_i,
  output logic                   ack_o,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic                   ref_req_i,
  input  logic                   init_done_i,
  output logic                   ref_grant_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic [DA_W-1:0]        dram_addr_o,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int unsigned TMR_W = 8;
  localparam int unsigned CNT_W = 8;

  seq_state_e        state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, keep_q, ack_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              take, hit, grant, done;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  assign req_row = addr_i[ROW_W+COL_W-1:COL_W];
  assign req_col = addr_i[COL_W-1:0];

  always_comb begin
    state_d = state_q;
    tmr_d   = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
    take    = 1'b0;
    hit     = 1'b0;
    grant   = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req_i) begin
          grant   = 1'b1;
          state_d = S_REF_CSR;
          tmr_d   = TMR_W'(T_CSR - 1);
        end else if (req_i && init_done_i) begin
          take    = 1'b1;
          state_d = S_RAS_DLY;
          tmr_d   = TMR_W'(T_RCD - 1);
        end
      end
      S_RAS_DLY: if (tmr_q == '0) begin
        state_d = S_CAS_LO;
        tmr_d   = TMR_W'(T_CAS - 1);
      end
      S_CAS_LO: if (tmr_q == '0) begin
        done    = 1'b1;
        state_d = S_CAS_PRE;
        tmr_d   = TMR_W'(T_CP - 1);
      end
      S_CAS_PRE: if (tmr_q == '0) state_d = S_PAGE_HOLD;
      // decision point: the ack of the last access is at least one cycle old here
      S_PAGE_HOLD: begin
        if (ref_req_i || (req_i && req_row != row_q) || (!req_i && !keep_q)) begin
          state_d = S_PRECHG;
          tmr_d   = TMR_W'(T_RP - 1);
        end else if (req_i) begin
          hit     = 1'b1;
          state_d = S_CAS_LO;
          tmr_d   = TMR_W'(T_CAS - 1);
        end
      end
      S_PRECHG: if (tmr_q == '0) state_d = S_IDLE;
      S_REF_CSR: if (tmr_q == '0) begin
        state_d = S_REF_RAS;
        tmr_d   = TMR_W'(T_RAS - 1);
      end
      S_REF_RAS: if (tmr_q == '0) begin
        state_d = S_PRECHG;
        tmr_d   = TMR_W'(T_RP - 1);
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      keep_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      ack_q   <= done;
      if (take) row_q <= req_row;
      if (take || hit) begin
        col_q   <= req_col;
        wr_q    <= we_i;
        keep_q  <= burst_i;
        wdata_q <= wdata_i;
      end
      if (done && !wr_q) rdata_q <= dram_dq_i;
    end
  end

  logic ras_act, cas_act, wr_act;
  assign ras_act = (state_q == S_RAS_DLY) || (state_q == S_CAS_LO) || (state_q == S_CAS_PRE) ||
                   (state_q == S_PAGE_HOLD) || (state_q == S_REF_RAS);
  assign cas_act = (state_q == S_CAS_LO) || (state_q == S_REF_CSR) || (state_q == S_REF_RAS);
  assign wr_act  = (state_q == S_CAS_LO) && wr_q;

  assign dram_ras_no  = !ras_act;
  assign dram_cas_no  = !cas_act;
  assign dram_we_no   = !wr_act;
  assign dram_dq_oe_o = wr_act;
  assign dram_dq_o    = wdata_q;
  assign dram_addr_o  = (state_q == S_RAS_DLY) ? DA_W'(row_q) : DA_W'(col_q);
  assign ref_grant_o  = grant;
  assign ack_o        = ack_q;
  assign rdata_o      = rdata_q;

  // pin-level history for the timing checks below
  logic [CNT_W-1:0] ras_hi_cnt, cas_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_hi_cnt <= '0;
      cas_lo_cnt <= '0;
    end else begin
      ras_hi_cnt <= !dram_ras_no ? '0 : (&ras_hi_cnt ? ras_hi_cnt : ras_hi_cnt + 1'b1);
      cas_lo_cnt <= dram_cas_no ? '0 : (&cas_lo_cnt ? cas_lo_cnt : cas_lo_cnt + 1'b1);
    end
  end

  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_ack_after_init_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> init_done_i);
  assert_ras_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (ras_hi_cnt >= CNT_W'(T_RP)));
  assert_cbr_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && !dram_cas_no) |-> (dram_we_no && cas_lo_cnt >= CNT_W'(T_CSR)));
  assert_cas_in_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> !dram_ras_no);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int unsigned ROW_W        = 11,
  parameter int unsigned COL_W        = 11,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 4,
  parameter int unsigned T_CP         = 1,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned INIT_WAIT    = 20000,
  parameter int unsigned INIT_REFRESH = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_i,
  input  logic                                   we_i,
  input  logic [ROW_W+COL_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  input  logic                                   burst_i,
  output logic                                   ack_o,
  output logic [DATA_W-1:0]                      rdata_o,
  output logic                                   dram_ras_no,
  output logic                                   dram_cas_no,
  output logic                                   dram_we_no,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   dram_addr_o,
  output logic [DATA_W-1:0]                      dram_dq_o,
  output logic                                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]                      dram_dq_i
);
  localparam int unsigned DA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic ref_req, ref_grant, init_done;

  fpm_refresh_sched #(
    .REF_INTERVAL(REF_INTERVAL),
    .INIT_WAIT   (INIT_WAIT),
    .INIT_REFRESH(INIT_REFRESH)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (ref_grant),
    .ref_req_o  (ref_req),
    .init_done_o(init_done)
  );

  fpm_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .DA_W  (DA_W),
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_CP  (T_CP),
    .T_RP  (T_RP),
    .T_CSR (T_CSR),
    .T_RAS (T_RAS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .burst_i     (burst_i),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .ref_req_i   (ref_req),
    .init_done_i (init_done),
    .ref_grant_o (ref_grant),
    .dram_ras_no (dram_ras_no),
    .dram_cas_no (dram_cas_no),
    .dram_we_no  (dram_we_no),
    .dram_addr_o (dram_addr_o),
    .dram_dq_o   (dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe_o),
    .dram_dq_i   (dram_dq_i)
  );
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
  localparam int T_RCD = 2, T_CAS = 4, T_CP = 1, T_RP = 4, T_CSR = 1, T_RAS = 6;
  localparam int REF_INTERVAL = 300, INIT_WAIT = 100, INIT_REFRESH = 8;
  localparam int SLACK = 24;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, burst = 1'b0;
  logic [21:0] haddr = '0;
  logic [31:0] hwdata = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic        ras_n, cas_n, we_n, dq_oe;
  logic [10:0] daddr;
  logic [31:0] dq_o;
  logic [31:0] dq_i = 32'h0BAD_BAD0;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .REF_INTERVAL(REF_INTERVAL), .INIT_WAIT(INIT_WAIT), .INIT_REFRESH(INIT_REFRESH)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(haddr), .wdata_i(hwdata),
    .burst_i(burst), .ack_o(ack_o), .rdata_o(rdata_o), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_addr_o(daddr), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req_tag, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [21:0] a);
    return 32'hDEAD_0000 ^ {10'd0, a};
  endfunction

  // array model and pin timing monitor, sampled at negedge
  logic [31:0] mem_m [logic [21:0]];
  logic [31:0] ref_m [logic [21:0]];
  longint cyc = 0, ras_fall_cyc = 0, last_ref = 0;
  int ras_hi = 0, cas_lo = 0, cas_hi = 0, ref_cnt = 0, act_cnt = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_ack = 1'b0;
  logic [10:0] cur_row = '0, cur_col = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        chk(ras_hi >= T_RP, "R5", "row strobe precharge cycles", ras_hi, T_RP);
        if (!cas_n) begin
          chk(we_n == 1'b1, "R3", "write enable in refresh", we_n, 1);
          chk(cas_lo >= T_CSR, "R3", "column-first setup cycles", cas_lo, T_CSR);
          ref_cnt++;
          if (ref_cnt > INIT_REFRESH + 1)
            chk((cyc - last_ref <= REF_INTERVAL + SLACK) && (cyc - last_ref + SLACK >= REF_INTERVAL),
                "R4", "refresh gap", cyc - last_ref, REF_INTERVAL);
          last_ref = cyc;
        end else begin
          act_cnt++;
          cur_row = daddr;
          ras_fall_cyc = cyc;
          chk(ref_cnt >= INIT_REFRESH, "R2", "refreshes before activation", ref_cnt, INIT_REFRESH);
          chk(cyc >= INIT_WAIT, "R2", "cycles before activation", cyc, INIT_WAIT);
          chk(daddr == haddr[21:11], "R5", "row address", daddr, haddr[21:11]);
        end
      end
      if (!ras_n && prev_ras && !cas_n && !prev_cas) begin end
      if (ras_n == 1'b0 && !cas_n && cas_hi > 0 && !(prev_ras && !ras_n)) begin
        // column strobe fell inside an open row
        cur_col = daddr;
        chk(daddr == haddr[10:0], "R6", "column address", daddr, haddr[10:0]);
        chk(cyc - ras_fall_cyc >= T_RCD, "R5", "row to column delay", cyc - ras_fall_cyc, T_RCD);
        chk(cas_hi >= T_CP, "R8", "column precharge cycles", cas_hi, T_CP);
        if (!we_n) begin
          chk(dq_oe == 1'b1, "R6", "data output enable", dq_oe, 1);
          chk(dq_o == hwdata, "R6", "write data", dq_o, hwdata);
          mem_m[{cur_row, cur_col}] = dq_o;
        end
      end
      if (!cas_n && ras_n && we_n == 1'b0)
        chk(1'b0, "R3", "write enable low outside row", 0, 1);
      if (ack_o && prev_ack) chk(1'b0, "R10", "ack longer than one cycle", 2, 1);
      if (!cas_n && !ras_n && we_n) begin
        if (mem_m.exists({cur_row, cur_col})) dq_i <= mem_m[{cur_row, cur_col}];
        else dq_i <= pat({cur_row, cur_col});
      end else dq_i <= 32'h0BAD_BAD0;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = !cas_n ? cas_lo + 1 : 0;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_ack = ack_o;
    end
  end

  longint first_ack_cyc = -1;
  task automatic xfer(input bit w, input logic [21:0] a, input logic [31:0] d, input bit b);
    logic [31:0] exp;
    req = 1'b1; we = w; haddr = a; hwdata = d; burst = b;
    do @(negedge clk); while (!ack_o);
    if (first_ack_cyc < 0) first_ack_cyc = cyc;
    if (w) ref_m[a] = d;
    else begin
      exp = ref_m.exists(a) ? ref_m[a] : pat(a);
      chk(rdata_o == exp, "R7", "read data", rdata_o, exp);
    end
    req = 1'b0; burst = 1'b0;
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_test();
  end

  initial begin
    int a0, r0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe, "R1", "pins in reset", {ras_n, cas_n, we_n, dq_oe}, 4'b1110);
    chk(ack_o == 1'b0, "R1", "ack in reset", ack_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe, "R1", "pins after reset", {ras_n, cas_n, we_n, dq_oe}, 4'b1110);

    // request held across initialisation
    xfer(1'b1, 22'h12_3456, 32'hCAFE_0001, 1'b0);
    chk(first_ack_cyc >= INIT_WAIT + INIT_REFRESH * (T_CSR + T_RAS + T_RP), "R2",
        "first ack cycle", first_ack_cyc, INIT_WAIT + INIT_REFRESH * (T_CSR + T_RAS + T_RP));
    chk(ref_cnt >= INIT_REFRESH, "R2", "init refresh count", ref_cnt, INIT_REFRESH);

    // scattered rows, write then read back
    for (int i = 0; i < 6; i++) xfer(1'b1, 22'(i * 22'h0A_5A3 + 22'h801), 32'h1111_1111 * (i + 1), 1'b0);
    for (int i = 0; i < 6; i++) xfer(1'b0, 22'(i * 22'h0A_5A3 + 22'h801), 32'h0, 1'b0);
    xfer(1'b0, 22'h12_3456, 32'h0, 1'b0);
    xfer(1'b0, 22'h3F_FFFF, 32'h0, 1'b0);  // never written: array default

    // open-page burst in one row
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 0; i < 8; i++) xfer(1'b1, {11'h2A5, 11'(i * 37)}, 32'h8000_0000 >> i, 1'b1);
    for (int i = 0; i < 8; i++) xfer(1'b0, {11'h2A5, 11'(i * 37)}, 32'h0, (i != 7));
    chk((act_cnt - a0 >= 1) && (act_cnt - a0 <= 1 + (ref_cnt - r0)), "R8", "activations in burst",
        act_cnt - a0, 1 + (ref_cnt - r0));

    // row change while a row is open
    a0 = act_cnt; r0 = ref_cnt;
    xfer(1'b1, {11'h011, 11'h005}, 32'hA5A5_0011, 1'b1);
    xfer(1'b1, {11'h722, 11'h005}, 32'hA5A5_0722, 1'b0);
    chk(act_cnt - a0 >= 2, "R9", "activations on row change", act_cnt - a0, 2);
    xfer(1'b0, {11'h011, 11'h005}, 32'h0, 1'b0);
    xfer(1'b0, {11'h722, 11'h005}, 32'h0, 1'b0);

    // row held open across idle time: refreshes must still run and close it
    xfer(1'b1, {11'h155, 11'h100}, 32'h5555_AAAA, 1'b1);
    a0 = act_cnt; r0 = ref_cnt;
    repeat (2 * REF_INTERVAL + 50) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R4", "refreshes while row held", ref_cnt - r0, 2);
    xfer(1'b0, {11'h155, 11'h100}, 32'h0, 1'b0);
    chk(act_cnt - a0 == 1, "R4", "reactivation after refresh", act_cnt - a0, 1);

    // walking data patterns on one address, page mode disabled
    for (int i = 0; i < 32; i += 7) begin
      xfer(1'b1, 22'h2B_CDE, 32'h1 << i, 1'b0);
      xfer(1'b0, 22'h2B_CDE, 32'h0, 1'b0);
    end

    repeat (20) @(negedge clk);
    finish_test();
  end
endmodule